// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide programming front end of an eight-input interrupt controller. Software sees two register addresses. A write is sorted into one of two kinds. The first kind is a step of the multi-byte initialization sequence. The second kind is a run-time operation command: a mask load, an end-of-interrupt request or a read-select change. The block holds all configuration state and drives it out as registered fields: trigger style, single or chained use, vector base, chaining bits, automatic end-of-interrupt and the mask. The priority core that it feeds lives outside the block.

The initialization sequence starts with a control byte at address 0. Flags captured from that byte decide how many address-1 bytes follow. The sequence shares address 1 with the mask load, so the same write means different things depending on the sequence position.

End-of-interrupt commands leave the block as a one-cycle strobe carrying a line number. For the nonspecific form, that line number is computed from the in-service vector supplied by the core. Commands for rotation, special masking and buffering are accepted and have no effect. Reads are combinational. Address 0 returns the pending vector or the in-service vector, depending on the read-select flag. Address 1 returns the mask.

Top module: `pic_cmd_decoder`

## Requirements
- R1: A write to address 0 with data bit 4 set is a start byte, accepted at any time and restarting any sequence in progress. On the next cycle: `cfg_imr` is 0, `cfg_edge` equals bit 3, `cfg_cascade` equals the inverse of bit 1, `init_busy` is 1, and if bit 0 is 0 then `cfg_auto_eoi` is 0.
- R2: The first address-1 write after a start byte sets `cfg_vec_base` to data bits 7:3 and leaves `cfg_imr` unchanged.
- R3: If the start byte selected single use (bit 1 = 1), the sequence ends after the vector byte. `cfg_casc_bits` becomes 0 and `init_busy` falls, even if a mode byte was requested.
- R4: In chained use, the third byte loads `cfg_casc_bits`. With `is_primary`=1 it loads all 8 bits. With `is_primary`=0 it loads data bits 2:0 zero-extended. The sequence then waits for a mode byte if start-byte bit 0 was 1, and otherwise ends.
- R5: The mode byte sets `cfg_auto_eoi` to data bit 1 and ends the sequence.
- R6: An address-1 write while `init_busy` is 0 loads `cfg_imr` with the data. Address-1 writes that belong to the sequence never change `cfg_imr`.
- R7: An address-0 write with bits 4:3 = 00 and bits 7:5 = 001 pulses `eoi_valid` for exactly one cycle, starting the cycle after the write, with `eoi_line` set to the index of the highest set bit of `isr_in`. If `isr_in` is 0, no pulse is issued.
- R8: The same write form with bits 7:5 = 011 pulses `eoi_valid` with `eoi_line` equal to data bits 2:0.
- R9: With bits 4:3 = 00, the codes 000, 010, 100, 101, 110 and 111 in bits 7:5 issue no pulse and change no state.
- R10: An address-0 write with bits 4:3 = 01 and bit 1 = 1 sets `rd_sel_irr` to data bit 0. The same write with bit 1 = 0 leaves it unchanged.
- R11: `rd_data` at address 0 is `irr_in` when `rd_sel_irr`=1 and `isr_in` when it is 0. At address 1 it is `cfg_imr`.
- R12: After reset: `cfg_imr`=0, `init_busy`=0, `eoi_valid`=0, `rd_sel_irr`=1, and all other configuration fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| reg_addr | input | 1 | Register address, for both reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| is_primary | input | 1 | 1: chaining byte is a line bitmap; 0: it is a 3-bit identity |
| irr_in | input | 8 | Pending vector from the priority core |
| isr_in | input | 8 | In-service vector from the priority core |
| eoi_valid | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_line | output | 3 | Line to retire with the strobe |
| cfg_edge | output | 1 | 1 = edge-triggered inputs |
| cfg_cascade | output | 1 | 1 = chained use |
| cfg_vec_base | output | 5 | Upper bits of the vector number |
| cfg_casc_bits | output | 8 | Chaining bitmap or identity |
| cfg_auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| cfg_imr | output | 8 | Interrupt mask |
| rd_sel_irr | output | 1 | Address-0 read selects the pending vector |
| init_busy | output | 1 | Initialization sequence in progress |

## Verification
A wrong sequence position shows up on the first address-1 write that follows. The byte either lands in the mask and is visible at address 1 on the next read, or it lands in a configuration field while `init_busy` stays high. Either error is therefore visible one cycle after the write that exposes it. A wrong end-of-interrupt decode shows as a missing or extra `eoi_valid` pulse, or as a wrong `eoi_line`, in the cycle right after the command. Start bytes issued mid-sequence and single-use sequences that requested a mode byte are the cases that separate a correct sequencer from one that merely counts bytes.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_VEC  = 2'd1,
    SEQ_CHN  = 2'd2,
    SEQ_MODE = 2'd3
  } seq_t;

  // command code in data[7:5] when data[4:3] == 2'b00
  localparam logic [2:0] OP_EOI_ANY  = 3'b001;
  localparam logic [2:0] OP_EOI_LINE = 3'b011;
  localparam logic [1:0] SEL_OPCMD   = 2'b00;
  localparam logic [1:0] SEL_RDCMD   = 2'b01;
endpackage

// File: rtl/pic_rst_sync.sv
module pic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shreg[STAGES-1];
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int unsigned LINES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        reg_addr,
  input  logic [BYTE_W-1:0]           wr_data,
  input  logic                        is_primary,
  output logic                        cfg_edge,
  output logic                        cfg_cascade,
  output logic [BYTE_W-$clog2(LINES)-1:0] cfg_vec_base,
  output logic [LINES-1:0]            cfg_casc_bits,
  output logic                        cfg_auto_eoi,
  output logic [LINES-1:0]            cfg_imr,
  output logic                        init_busy
);
  localparam int unsigned LINE_W = $clog2(LINES);
  localparam int unsigned VB_W   = BYTE_W - LINE_W;

  seq_t              seq_q, seq_n;
  logic              want_mode_q, want_mode_n;
  logic              edge_n, casc_n, aeoi_n;
  logic [VB_W-1:0]   vbase_n;
  logic [LINES-1:0]  cbits_n, imr_n;
  logic              start_wr, hi_wr, state_en;

  assign start_wr = wr_en && !reg_addr && wr_data[4];
  assign hi_wr    = wr_en && reg_addr;
  assign state_en = start_wr || hi_wr;

  always_comb begin
    seq_n       = seq_q;
    want_mode_n = want_mode_q;
    edge_n      = cfg_edge;
    casc_n      = cfg_cascade;
    aeoi_n      = cfg_auto_eoi;
    vbase_n     = cfg_vec_base;
    cbits_n     = cfg_casc_bits;
    imr_n       = cfg_imr;
    if (start_wr) begin
      seq_n       = SEQ_VEC;
      imr_n       = '0;
      edge_n      = wr_data[3];
      casc_n      = !wr_data[1];
      want_mode_n = wr_data[0];
      if (!wr_data[0]) aeoi_n = 1'b0;
    end else if (hi_wr) begin
      unique case (seq_q)
        SEQ_IDLE: imr_n = wr_data[LINES-1:0];
        SEQ_VEC: begin
          vbase_n = wr_data[BYTE_W-1:LINE_W];
          if (cfg_cascade) begin
            seq_n = SEQ_CHN;
          end else begin
            cbits_n = '0;
            seq_n   = SEQ_IDLE;
          end
        end
        SEQ_CHN: begin
          if (is_primary) cbits_n = wr_data[LINES-1:0];
          else            cbits_n = {{(LINES-LINE_W){1'b0}}, wr_data[LINE_W-1:0]};
          seq_n = want_mode_q ? SEQ_MODE : SEQ_IDLE;
        end
        SEQ_MODE: begin
          aeoi_n = wr_data[1];
          seq_n  = SEQ_IDLE;
        end
        default: seq_n = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q         <= SEQ_IDLE;
      want_mode_q   <= 1'b0;
      cfg_edge      <= 1'b0;
      cfg_cascade   <= 1'b0;
      cfg_auto_eoi  <= 1'b0;
      cfg_vec_base  <= '0;
      cfg_casc_bits <= '0;
      cfg_imr       <= '0;
    end else if (state_en) begin
      seq_q         <= seq_n;
      want_mode_q   <= want_mode_n;
      cfg_edge      <= edge_n;
      cfg_cascade   <= casc_n;
      cfg_auto_eoi  <= aeoi_n;
      cfg_vec_base  <= vbase_n;
      cfg_casc_bits <= cbits_n;
      cfg_imr       <= imr_n;
    end
  end

  assign init_busy = (seq_q != SEQ_IDLE);
endmodule

// File: rtl/pic_op_decode.sv
module pic_op_decode
  import pic_cmd_pkg::*;
#(
  parameter int unsigned LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     reg_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [LINES-1:0]         isr_in,
  output logic                     eoi_valid,
  output logic [$clog2(LINES)-1:0] eoi_line,
  output logic                     rd_sel_irr
);
  localparam int unsigned LINE_W = $clog2(LINES);

  logic              lo_wr, op_wr, rd_wr;
  logic              top_found;
  logic [LINE_W-1:0] top_line;
  logic              eoi_n;
  logic [LINE_W-1:0] line_n;
  logic              sel_n, sel_en;

  assign lo_wr = wr_en && !reg_addr;
  assign op_wr = lo_wr && (wr_data[4:3] == SEL_OPCMD);
  assign rd_wr = lo_wr && (wr_data[4:3] == SEL_RDCMD);

  // highest set in-service bit
  always_comb begin
    top_found = 1'b0;
    top_line  = '0;
    for (int i = 0; i < LINES; i++) begin
      if (isr_in[i]) begin
        top_found = 1'b1;
        top_line  = LINE_W'(i);
      end
    end
  end

  always_comb begin
    eoi_n  = 1'b0;
    line_n = '0;
    if (op_wr) begin
      if (wr_data[7:5] == OP_EOI_ANY && top_found) begin
        eoi_n  = 1'b1;
        line_n = top_line;
      end else if (wr_data[7:5] == OP_EOI_LINE) begin
        eoi_n  = 1'b1;
        line_n = wr_data[LINE_W-1:0];
      end
    end
  end

  assign sel_en = rd_wr && wr_data[1];
  assign sel_n  = wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_valid <= 1'b0;
      eoi_line  <= '0;
    end else begin
      eoi_valid <= eoi_n;
      eoi_line  <= line_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_sel_irr <= 1'b1;
    else if (sel_en) rd_sel_irr <= sel_n;
  end
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux #(
  parameter int unsigned W = 8
) (
  input  logic         reg_addr,
  input  logic         rd_sel_irr,
  input  logic [W-1:0] irr_in,
  input  logic [W-1:0] isr_in,
  input  logic [W-1:0] imr,
  output logic [W-1:0] rd_data
);
  always_comb begin
    if (reg_addr)        rd_data = imr;
    else if (rd_sel_irr) rd_data = irr_in;
    else                 rd_data = isr_in;
  end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter int unsigned LINES = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             reg_addr,
  input  logic [BYTE_W-1:0]                wr_data,
  output logic [BYTE_W-1:0]                rd_data,
  input  logic                             is_primary,
  input  logic [LINES-1:0]                 irr_in,
  input  logic [LINES-1:0]                 isr_in,
  output logic                             eoi_valid,
  output logic [$clog2(LINES)-1:0]         eoi_line,
  output logic                             cfg_edge,
  output logic                             cfg_cascade,
  output logic [BYTE_W-$clog2(LINES)-1:0]  cfg_vec_base,
  output logic [LINES-1:0]                 cfg_casc_bits,
  output logic                             cfg_auto_eoi,
  output logic [LINES-1:0]                 cfg_imr,
  output logic                             rd_sel_irr,
  output logic                             init_busy
);
  logic rst_n_s;

  pic_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  pic_init_seq #(.LINES(LINES)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .is_primary(is_primary),
    .cfg_edge(cfg_edge), .cfg_cascade(cfg_cascade),
    .cfg_vec_base(cfg_vec_base), .cfg_casc_bits(cfg_casc_bits),
    .cfg_auto_eoi(cfg_auto_eoi), .cfg_imr(cfg_imr), .init_busy(init_busy)
  );

  pic_op_decode #(.LINES(LINES)) u_op (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .isr_in(isr_in), .eoi_valid(eoi_valid),
    .eoi_line(eoi_line), .rd_sel_irr(rd_sel_irr)
  );

  pic_rd_mux #(.W(BYTE_W)) u_rd (
    .reg_addr(reg_addr), .rd_sel_irr(rd_sel_irr), .irr_in(irr_in),
    .isr_in(isr_in), .imr(cfg_imr), .rd_data(rd_data)
  );
endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       reg_addr,
  input logic [7:0] wr_data,
  input logic [7:0] isr_in,
  input logic       eoi_valid,
  input logic [2:0] eoi_line,
  input logic [7:0] cfg_imr,
  input logic       rd_sel_irr,
  input logic       init_busy
);
  logic start_wr, op_wr;
  assign start_wr = wr_en && !reg_addr && wr_data[4];
  assign op_wr    = wr_en && !reg_addr && (wr_data[4:3] == 2'b00);

  AST_START_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (cfg_imr == 8'h00) && init_busy); // R1

  AST_MASK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_imr)); // R6

  AST_EOI_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_wr && (wr_data[7:5] == 3'b001 || wr_data[7:5] == 3'b011)) |=> !eoi_valid); // R9

  AST_EOI_LINE_GIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && wr_data[7:5] == 3'b011) |=> eoi_valid && (eoi_line == $past(wr_data[2:0]))); // R8

  AST_EOI_ANY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && wr_data[7:5] == 3'b001 && isr_in != 8'h00) |=> eoi_valid); // R7

  AST_RDSEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_addr && wr_data[4:3] == 2'b01 && wr_data[1]) |=> (rd_sel_irr == $past(wr_data[0]))); // R10
endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .reg_addr(reg_addr),
  .wr_data(wr_data), .isr_in(isr_in), .eoi_valid(eoi_valid),
  .eoi_line(eoi_line), .cfg_imr(cfg_imr), .rd_sel_irr(rd_sel_irr),
  .init_busy(init_busy)
);

// File: tb/pic_cmd_decoder_bench.sv
module pic_cmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       is_primary = 1'b1;
  logic [7:0] irr_in = 8'hA5;
  logic [7:0] isr_in = 8'h3C;
  logic       eoi_valid;
  logic [2:0] eoi_line;
  logic       cfg_edge, cfg_cascade, cfg_auto_eoi, rd_sel_irr, init_busy;
  logic [4:0] cfg_vec_base;
  logic [7:0] cfg_casc_bits, cfg_imr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pic_cmd_decoder u_pic_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .is_primary(is_primary),
    .irr_in(irr_in), .isr_in(isr_in), .eoi_valid(eoi_valid),
    .eoi_line(eoi_line), .cfg_edge(cfg_edge), .cfg_cascade(cfg_cascade),
    .cfg_vec_base(cfg_vec_base), .cfg_casc_bits(cfg_casc_bits),
    .cfg_auto_eoi(cfg_auto_eoi), .cfg_imr(cfg_imr),
    .rd_sel_irr(rd_sel_irr), .init_busy(init_busy)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [17:0] VEC [10] = '{
    {1'b1, 8'h5A, 1'b1, 8'h5A},  // R6 mask load when idle
    {1'b0, 8'h0A, 1'b0, 8'h3C},  // R10 select in-service
    {1'b0, 8'h0B, 1'b0, 8'hA5},  // R10 select pending
    {1'b0, 8'h08, 1'b0, 8'hA5},  // R10 bit1=0 keeps select
    {1'b0, 8'h11, 1'b1, 8'h00},  // R1 start clears mask
    {1'b1, 8'h20, 1'b1, 8'h00},  // R2 vector byte not in mask
    {1'b1, 8'h04, 1'b1, 8'h00},  // R4 chain byte not in mask
    {1'b1, 8'h03, 1'b1, 8'h00},  // R5 mode byte not in mask
    {1'b1, 8'hC3, 1'b1, 8'hC3},  // R6 mask load after sequence
    {1'b0, 8'h0A, 1'b0, 8'h3C}   // R11 in-service read
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    rd(1'b0, v); chk("R12 addr0 reads pending", v, 8'hA5);
    rd(1'b1, v); chk("R12 mask", v, 8'h00);
    chk("R12 busy/eoi/sel", {5'b0, init_busy, eoi_valid, rd_sel_irr}, 8'h01);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][17], VEC[i][16:9]);
      rd(VEC[i][8], v);
      chk($sformatf("R11 vector %0d", i), v, VEC[i][7:0]);
    end
    chk("R4 primary chain bitmap", cfg_casc_bits, 8'h04);
    chk("R2 vector base", {3'b0, cfg_vec_base}, 8'h04);
    chk("R5 auto eoi set", {7'b0, cfg_auto_eoi}, 8'h01);
    chk("R1 level chained", {6'b0, cfg_edge, cfg_cascade}, 8'h01);

    // R1 + R3 single use, no mode byte: auto-eoi cleared
    wr(1'b0, 8'h1A);
    chk("R1 busy edge autoeoi", {5'b0, init_busy, cfg_edge, cfg_auto_eoi}, 8'h06);
    chk("R1 single use", {7'b0, cfg_cascade}, 8'h00);
    wr(1'b1, 8'h47);
    chk("R3 end after vector", {7'b0, init_busy}, 8'h00);
    chk("R3 chain cleared", cfg_casc_bits, 8'h00);
    chk("R2 base from 47", {3'b0, cfg_vec_base}, 8'h08);
    wr(1'b1, 8'h12);
    chk("R6 mask after single", cfg_imr, 8'h12);

    // R3 single use with mode byte requested still ends after vector
    wr(1'b0, 8'h11); wr(1'b1, 8'h08);            // chained, now at chain byte
    wr(1'b0, 8'h13);                              // R1 restart mid-sequence
    chk("R1 restart busy", {7'b0, init_busy}, 8'h01);
    wr(1'b1, 8'h28);
    chk("R3 mode byte skipped", {7'b0, init_busy}, 8'h00);
    chk("R2 restart base", {3'b0, cfg_vec_base}, 8'h05);

    // R4 secondary role, no mode byte
    is_primary = 1'b0;
    wr(1'b0, 8'h10); wr(1'b1, 8'h70); wr(1'b1, 8'hFE);
    chk("R4 secondary id", cfg_casc_bits, 8'h06);
    chk("R4 ends without mode byte", {7'b0, init_busy}, 8'h00);
    chk("R1 autoeoi cleared", {7'b0, cfg_auto_eoi}, 8'h00);
    wr(1'b1, 8'h33);
    chk("R6 mask after secondary", cfg_imr, 8'h33);

    // End-of-interrupt commands
    isr_in = 8'b0010_1100;
    wr(1'b0, 8'h20);
    chk("R7 nonspecific strobe", {4'b0, eoi_valid, eoi_line}, 8'h0D);
    @(negedge clk);
    chk("R7 strobe one cycle", {7'b0, eoi_valid}, 8'h00);
    wr(1'b0, 8'h63);
    chk("R8 specific line", {4'b0, eoi_valid, eoi_line}, 8'h0B);
    wr(1'b0, 8'hE5);
    chk("R9 code 111 no strobe", {7'b0, eoi_valid}, 8'h00);
    wr(1'b0, 8'h40);
    chk("R9 code 010 no strobe", {7'b0, eoi_valid}, 8'h00);
    chk("R9 mask untouched", cfg_imr, 8'h33);
    isr_in = 8'h00;
    wr(1'b0, 8'h20);
    chk("R7 empty in-service no strobe", {7'b0, eoi_valid}, 8'h00);

    // R12 asynchronous reset returns to initial values
    rst_n = 1'b0;
    #1;
    chk("R12 mask after reset", cfg_imr, 8'h00);
    chk("R12 sel after reset", {7'b0, rd_sel_irr}, 8'h01);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule